// File: doc/BRIEF.md
# Context-Driven Reconfigurable Datapath Cell

This block is one 16-bit processing cell of a coarse-grained reconfigurable mesh. A 32-bit context word sets everything the cell does in a cycle. The same word is broadcast to a whole row or column of cells, so all of them run the same operation on their own operands. The cell picks two operands, either from its neighbours, from the row and column lanes, from its slice of a shared operand bus, or from its own four-entry register file. It then runs them through a combined ALU and multiplier, followed by a shifter. The result can be registered on the cell output, written back into the register file, or both.

The arithmetic unit takes four inputs: the two selected operands, the cell's own output register, and a 12-bit signed constant carried in the context word. The output register therefore works as an accumulator, which allows a multiply-accumulate in a single cycle, including a variant that multiplies by the constant. A context load strobe captures a new word at a clock edge. That word controls the cell from the next cycle onward and stays in force until the next load, so one operation can repeat every cycle, for example a running accumulation.

Top module: `cgra_cell`

## Requirements
- R1: After reset the output is 0, all four register-file entries are 0, and the held context is all zeros. An all-zero context is idle: it writes neither the output register nor the register file.
- R2: When `ctx_load` is high at a rising edge, `ctx_word` is captured. The captured word controls the operation executed in the following cycle, and its result appears after the next edge. Without a load, the held word is re-executed every cycle.
- R3: Operand select fields sit at bits [6:4] for A and [9:7] for B. The codes are: 0 north, 1 east, 2 south, 3 west, 4 row lane, 5 column lane, 6 operand bus segment, 7 register-file entry addressed by the destination field.
- R4: Opcode bits [3:0] give these operations: 0 pass A, 1 A+B, 2 A−B, 3 AND, 4 OR, 5 XOR, 6 NOT A. Codes 12 to 15 also pass A. All arithmetic wraps modulo 2^16.
- R5: Opcode 7 gives the low 16 bits of A×B. Opcode 8 gives the current output plus A×B, keeping the low 16 bits.
- R6: Opcode 9 gives A×imm, 10 gives A+imm, and 11 gives the current output plus A×imm. Here imm is bits [30:19] sign-extended to 16 bits.
- R7: The shifter acts on the arithmetic result. Bits [13:10] give the amount, 0 to 15. Bit 14 selects the direction: 0 is a logical left shift, 1 is an arithmetic right shift.
- R8: When bit 18 is 1, the shifted result loads the output register. When it is 0, the output holds its value.
- R9: When bit 17 is 1, the shifted result is written into the register-file entry given by bits [16:15]. When it is 0, the register file is unchanged. The output load and the register write may happen in the same cycle.
- R10: Bit 31 of the context word has no effect on the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_load | input | 1 | Capture strobe for the context word |
| ctx_word | input | 32 | Context word broadcast along the row or column |
| bus_seg | input | 16 | This cell's slice of the shared operand bus |
| nbr_n | input | 16 | North neighbour output |
| nbr_e | input | 16 | East neighbour output |
| nbr_s | input | 16 | South neighbour output |
| nbr_w | input | 16 | West neighbour output |
| row_lane | input | 16 | Value from another cell in the same row |
| col_lane | input | 16 | Value from another cell in the same column |
| cell_out | output | 16 | Output register, also the accumulator |

## Verification
Context capture and execution overlap: on the edge where one context's result is registered, the next word is already being captured. The bench exercises this constantly by loading an idle word in the cycle that executes the operation under test. A correct cell shows exactly one result and no repeat. A held accumulation is then run for several cycles and stopped the same way. The output must step once per cycle and take one final step on the stopping edge. A second overlap, an output load together with a register-file write from the same result, is checked by reading the entry back through operand source 7.

// File: rtl/cgra_cell_pkg.sv
package cgra_cell_pkg;

   localparam int CTX_W   = 32;
   localparam int IMM_W   = 12;
   localparam int SHAMT_W = 4;
   localparam int SEL_W   = 3;
   localparam int OP_W    = 4;
   localparam int DST_W   = 2;
   localparam int N_SRC   = 2 ** SEL_W;

   typedef enum logic [OP_W-1:0] {
      OP_PASS  = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_AND   = 4'd3,
      OP_OR    = 4'd4,
      OP_XOR   = 4'd5,
      OP_NOT   = 4'd6,
      OP_MUL   = 4'd7,
      OP_MAC   = 4'd8,
      OP_MULI  = 4'd9,
      OP_ADDI  = 4'd10,
      OP_MACI  = 4'd11,
      OP_RSV_C = 4'd12,
      OP_RSV_D = 4'd13,
      OP_RSV_E = 4'd14,
      OP_RSV_F = 4'd15
   } op_e;

   typedef enum logic [SEL_W-1:0] {
      SRC_N   = 3'd0,
      SRC_E   = 3'd1,
      SRC_S   = 3'd2,
      SRC_W   = 3'd3,
      SRC_ROW = 3'd4,
      SRC_COL = 3'd5,
      SRC_BUS = 3'd6,
      SRC_REG = 3'd7
   } src_e;

   typedef struct packed {
      logic               spare;
      logic [IMM_W-1:0]   imm;
      logic               oe;
      logic               we;
      logic [DST_W-1:0]   dst;
      logic               sh_right;
      logic [SHAMT_W-1:0] sh_amt;
      src_e               sel_b;
      src_e               sel_a;
      op_e                op;
   } ctx_t;

endpackage

// File: rtl/cell_ctx_reg.sv
module cell_ctx_reg
   import cgra_cell_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CTX_W-1:0] word,
   output ctx_t             ctx
);

   if ($bits(ctx_t) != CTX_W) begin : g_bad_layout
      $error("context layout does not fill the context word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctx <= '0;
      else if (load)
         ctx <= ctx_t'(word);
   end

   AST_CTX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ctx == ctx_t'($past(word)))); // R2
   AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ctx)); // R2

endmodule

// File: rtl/cell_opmux.sv
module cell_opmux
   import cgra_cell_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [SEL_W-1:0]          sel,
   input  logic [N_SRC-1:0][DW-1:0]  srcs,
   output logic [DW-1:0]             y
);

   if (DW < 1) begin : g_bad_dw
      $error("operand width must be positive");
   end

   assign y = srcs[sel];

endmodule

// File: rtl/cell_regfile.sv
module cell_regfile #(
   parameter int DW   = 16,
   parameter int NREG = 4,
   localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   if (NREG < 2 || NREG != (1 << AW)) begin : g_bad_depth
      $error("register file depth must be a power of two, at least 2");
   end

   logic [NREG-1:0][DW-1:0] mem;

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (we && (waddr == AW'(i)))
            ent_q <= wdata;
      end
      assign mem[i] = ent_q;
   end

   assign rdata = mem[raddr];

   AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata))); // R9
   AST_RF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem)); // R9

endmodule

// File: rtl/cell_exec.sv
module cell_exec
   import cgra_cell_pkg::*;
#(
   parameter int DW        = 16,
   parameter int SHW       = SHAMT_W,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  op_e            op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   input  logic [DW-1:0]  acc,
   input  logic [DW-1:0]  imm,
   input  logic [SHW-1:0] sh_amt,
   input  logic           sh_right,
   output logic [DW-1:0]  res
);

   if ((1 << SHW) > DW) begin : g_bad_shift
      $error("shift amount range exceeds datapath width");
   end

   logic          use_imm_mul;
   logic [DW-1:0] mul_b;
   logic [DW-1:0] mul_lo;
   logic [DW-1:0] alu;

   // one multiplier shared by the register and the constant forms
   assign use_imm_mul = (op == OP_MULI) || (op == OP_MACI);
   assign mul_b       = use_imm_mul ? imm : b;
   assign mul_lo      = a * mul_b;

   always_comb begin
      case (op)
         OP_ADD:  alu = a + b;
         OP_SUB:  alu = a - b;
         OP_AND:  alu = a & b;
         OP_OR:   alu = a | b;
         OP_XOR:  alu = a ^ b;
         OP_NOT:  alu = ~a;
         OP_MUL:  alu = mul_lo;
         OP_MAC:  alu = acc + mul_lo;
         OP_MULI: alu = mul_lo;
         OP_ADDI: alu = a + imm;
         OP_MACI: alu = acc + mul_lo;
         default: alu = a;
      endcase
   end

   if (LOG_SHIFT) begin : g_log_shift
      always_comb begin
         logic [DW-1:0] st;
         st = alu;
         for (int k = 0; k < SHW; k++) begin
            if (sh_amt[k]) begin
               if (sh_right)
                  st = DW'($signed(st) >>> (1 << k));
               else
                  st = DW'(st << (1 << k));
            end
         end
         res = st;
      end
   end else begin : g_flat_shift
      always_comb begin
         if (sh_right)
            res = DW'($signed(alu) >>> sh_amt);
         else
            res = DW'(alu << sh_amt);
      end
   end

endmodule

// File: rtl/cgra_cell.sv
module cgra_cell
   import cgra_cell_pkg::*;
#(
   parameter int DW        = 16,
   parameter int NREG      = 4,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctx_load,
   input  logic [CTX_W-1:0] ctx_word,
   input  logic [DW-1:0]    bus_seg,
   input  logic [DW-1:0]    nbr_n,
   input  logic [DW-1:0]    nbr_e,
   input  logic [DW-1:0]    nbr_s,
   input  logic [DW-1:0]    nbr_w,
   input  logic [DW-1:0]    row_lane,
   input  logic [DW-1:0]    col_lane,
   output logic [DW-1:0]    cell_out
);

   localparam int N_OPND = 2;

   if (NREG != (1 << DST_W)) begin : g_bad_nreg
      $error("register count must match the destination field");
   end
   if (DW < IMM_W) begin : g_bad_imm
      $error("datapath narrower than the immediate field");
   end

   ctx_t                      ctx;
   logic [N_SRC-1:0][DW-1:0]  srcs;
   logic [N_OPND-1:0][DW-1:0] opnd;
   logic [DW-1:0]             rf_rd;
   logic [DW-1:0]             imm_x;
   logic [DW-1:0]             res;
   logic                      unused_spare;

   cell_ctx_reg u_ctx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctx_load),
      .word  (ctx_word),
      .ctx   (ctx)
   );

   assign unused_spare = ctx.spare;
   assign imm_x = {{(DW-IMM_W){ctx.imm[IMM_W-1]}}, ctx.imm};

   // source order follows the select code
   assign srcs = {rf_rd, bus_seg, col_lane, row_lane, nbr_w, nbr_s, nbr_e, nbr_n};

   for (genvar g = 0; g < N_OPND; g++) begin : g_opmux
      cell_opmux #(.DW(DW)) u_mux (
         .sel  ((g == 0) ? ctx.sel_a : ctx.sel_b),
         .srcs (srcs),
         .y    (opnd[g])
      );
   end

   cell_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctx.we),
      .waddr (ctx.dst),
      .wdata (res),
      .raddr (ctx.dst),
      .rdata (rf_rd)
   );

   cell_exec #(.DW(DW), .SHW(SHAMT_W), .LOG_SHIFT(LOG_SHIFT)) u_exec (
      .op       (ctx.op),
      .a        (opnd[0]),
      .b        (opnd[1]),
      .acc      (cell_out),
      .imm      (imm_x),
      .sh_amt   (ctx.sh_amt),
      .sh_right (ctx.sh_right),
      .res      (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cell_out <= '0;
      else if (ctx.oe)
         cell_out <= res;
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctx.oe |=> $stable(cell_out)); // R8
   AST_MAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx.oe && ctx.op == OP_MAC && ctx.sh_amt == '0)
      |=> (cell_out == DW'($past(cell_out) + $past(opnd[0]) * $past(opnd[1])))); // R5
   AST_ADDI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx.oe && ctx.op == OP_ADDI && ctx.sh_amt == '0)
      |=> (cell_out == DW'($past(opnd[0]) + $past(imm_x)))); // R6

endmodule

// File: tb/cgra_cell_tb.sv
module cgra_cell_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctx_load = 1'b0;
   logic [31:0] ctx_word = '0;
   logic [15:0] bus_seg = '0;
   logic [15:0] nbr_n = '0, nbr_e = '0, nbr_s = '0, nbr_w = '0;
   logic [15:0] row_lane = '0, col_lane = '0;
   logic [15:0] cell_out;

   int chk_cnt = 0;
   int fail_cnt = 0;

   always #10 clk = ~clk; // 50 MHz

   cgra_cell u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctx_load (ctx_load),
      .ctx_word (ctx_word),
      .bus_seg  (bus_seg),
      .nbr_n    (nbr_n),
      .nbr_e    (nbr_e),
      .nbr_s    (nbr_s),
      .nbr_w    (nbr_w),
      .row_lane (row_lane),
      .col_lane (col_lane),
      .cell_out (cell_out)
   );

   function automatic logic [31:0] mk(input logic [3:0] op, input logic [2:0] sa,
      input logic [2:0] sb, input logic [3:0] amt, input logic rt, input logic [1:0] dst,
      input logic we, input logic oe, input logic [11:0] imm, input logic sp);
      return {sp, imm, oe, we, dst, rt, amt, sb, sa, op};
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      chk_cnt++;
      if (got !== exp) begin
         fail_cnt++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // load w, then load idle during w's execution cycle
   task automatic run_once(input logic [31:0] w);
      ctx_word = w;
      ctx_load = 1'b1;
      @(posedge clk); @(negedge clk);
      ctx_word = '0;
      @(posedge clk); @(negedge clk);
      ctx_load = 1'b0;
   endtask

   task automatic read_rf(input logic [1:0] d);
      run_once(mk(4'd0, 3'd7, 3'd0, 4'd0, 1'b0, d, 1'b0, 1'b1, 12'd0, 1'b0));
   endtask

   task automatic t_reset;
      chk("R1 output after reset", cell_out, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R1 idle context keeps output", cell_out, 16'h0000);
      // B-mux sweep while rf[0] is still zero: XOR of 0 with source s
      nbr_n = 16'h0101; nbr_e = 16'h0202; nbr_s = 16'h0303; nbr_w = 16'h0404;
      row_lane = 16'h0505; col_lane = 16'h0606; bus_seg = 16'h0707;
      for (int s = 0; s < 7; s++) begin
         run_once(mk(4'd5, 3'd7, 3'(s), 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
         chk("R3 operand B select", cell_out, {2{8'(s + 1)}});
      end
      for (int d = 0; d < 4; d++) begin
         read_rf(2'(d));
         chk("R1 register file cleared", cell_out, 16'h0000);
      end
   endtask

   task automatic t_sources;
      for (int s = 0; s < 7; s++) begin
         run_once(mk(4'd0, 3'(s), 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
         chk("R3 operand A select", cell_out, {2{8'(s + 1)}});
      end
   endtask

   task automatic t_alu;
      logic [15:0] exp_v [7];
      exp_v = '{16'h00F0, 16'h0FFF, 16'hF1E1, 16'h0000, 16'h0FFF, 16'h0FFF, 16'hFF0F};
      nbr_n = 16'h00F0; nbr_e = 16'h0F0F;
      for (int o = 0; o < 7; o++) begin
         run_once(mk(4'(o), 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
         chk("R4 logic/arith op", cell_out, exp_v[o]);
      end
      run_once(mk(4'd13, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R4 reserved opcode passes A", cell_out, 16'h00F0);
      nbr_n = 16'hFFFF; nbr_e = 16'h0002;
      run_once(mk(4'd1, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R4 add wraps", cell_out, 16'h0001);
   endtask

   task automatic t_mac;
      nbr_n = 16'h1234; nbr_e = 16'h0100;
      run_once(mk(4'd7, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R5 multiply low half", cell_out, 16'h3400);
      bus_seg = 16'h0010;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      nbr_n = 16'h0003; nbr_e = 16'h0005;
      run_once(mk(4'd8, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R5 multiply-accumulate", cell_out, 16'h001F);
      bus_seg = 16'hFFF0;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      nbr_n = 16'h0004;
      run_once(mk(4'd8, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R5 accumulate wraps", cell_out, 16'h0004);
   endtask

   task automatic t_imm;
      nbr_n = 16'h0007;
      run_once(mk(4'd9, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'hFFD, 1'b0));
      chk("R6 multiply by negative constant", cell_out, 16'hFFEB);
      run_once(mk(4'd10, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'hFFD, 1'b0));
      chk("R6 add negative constant", cell_out, 16'h0004);
      nbr_n = 16'h0010;
      run_once(mk(4'd11, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'h010, 1'b0));
      chk("R6 accumulate with constant", cell_out, 16'h0104);
      nbr_n = 16'h0001;
      run_once(mk(4'd10, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'h7FF, 1'b0));
      chk("R6 largest positive constant", cell_out, 16'h0800);
   endtask

   task automatic t_shift;
      nbr_n = 16'h8421;
      run_once(mk(4'd0, 3'd0, 3'd0, 4'd4, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R7 left shift by 4", cell_out, 16'h4210);
      run_once(mk(4'd0, 3'd0, 3'd0, 4'd4, 1'b1, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R7 arithmetic right by 4", cell_out, 16'hF842);
      nbr_n = 16'h8000;
      run_once(mk(4'd0, 3'd0, 3'd0, 4'd15, 1'b1, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R7 arithmetic right by 15", cell_out, 16'hFFFF);
      nbr_n = 16'h0001;
      run_once(mk(4'd0, 3'd0, 3'd0, 4'd15, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R7 left shift by 15", cell_out, 16'h8000);
      nbr_n = 16'h4000;
      run_once(mk(4'd0, 3'd0, 3'd0, 4'd3, 1'b1, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R7 right shift of positive value", cell_out, 16'h0800);
   endtask

   task automatic t_writeback;
      // out currently 0x0800
      bus_seg = 16'hBEEF;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd2, 1'b1, 1'b0, 12'd0, 1'b0));
      chk("R8 output held with load bit clear", cell_out, 16'h0800);
      read_rf(2'd2);
      chk("R9 register written without output load", cell_out, 16'hBEEF);
      bus_seg = 16'h1234;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1, 12'd0, 1'b0));
      chk("R8 output loaded", cell_out, 16'h1234);
      read_rf(2'd2);
      chk("R9 register kept with write bit clear", cell_out, 16'hBEEF);
      bus_seg = 16'h5A5A;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 12'd0, 1'b0));
      chk("R9 output and register same cycle", cell_out, 16'h5A5A);
      bus_seg = 16'h0000;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      read_rf(2'd3);
      chk("R9 entry 3 from same-cycle write", cell_out, 16'h5A5A);
      read_rf(2'd1);
      chk("R9 untouched entry stays zero", cell_out, 16'h0000);
   endtask

   task automatic t_hold;
      bus_seg = 16'h0000;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0));
      nbr_n = 16'h0002; nbr_e = 16'h0003;
      ctx_word = mk(4'd8, 3'd0, 3'd1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b0);
      ctx_load = 1'b1;
      @(posedge clk); @(negedge clk);
      ctx_load = 1'b0;
      chk("R2 new context not active at capture edge", cell_out, 16'h0000);
      for (int c = 1; c <= 3; c++) begin
         @(posedge clk); @(negedge clk);
         chk("R2 held context repeats", cell_out, 16'(6 * c));
      end
      ctx_word = '0;
      ctx_load = 1'b1;
      @(posedge clk); @(negedge clk);
      ctx_load = 1'b0;
      chk("R2 old context runs on replacing edge", cell_out, 16'd24);
      @(posedge clk); @(negedge clk);
      chk("R2 idle context stops accumulation", cell_out, 16'd24);
   endtask

   task automatic t_spare;
      row_lane = 16'h0505;
      run_once(mk(4'd0, 3'd4, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0, 1'b1));
      chk("R10 spare bit ignored", cell_out, 16'h0505);
      bus_seg = 16'h7777;
      run_once(mk(4'd0, 3'd6, 3'd0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 12'd0, 1'b1));
      chk("R10 spare bit does not load output", cell_out, 16'h0505);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sources();
      t_alu();
      t_mac();
      t_imm();
      t_shift();
      t_writeback();
      t_hold();
      t_spare();
      $display("== %0d vectors applied, %0d miscompares ==", chk_cnt, fail_cnt);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk_cnt++;
      fail_cnt++;
      $display("FAIL R2 watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", chk_cnt, fail_cnt);
      $finish;
   end

endmodule